// File: doc/BRIEF.md
# Half-Band 2x Interpolation Filter

This block doubles the sample rate of a complex baseband stream. It accepts 16-bit I and Q samples, qualified by a valid strobe that is high on at most every second clock. For each accepted sample it emits two output samples on consecutive clocks. The clock runs at twice the input sample rate, for example 122.88 Msps in and 245.76 Msps out on a 245.76 MHz clock. The filter is a 55-tap (order 54) half-band low-pass designed for about 98 MHz of occupied bandwidth.

The design relies on the half-band structure. Apart from the centre, every tap at an even distance from the centre is zero, and the centre tap together with the zero-stuffing gain of two is exactly one. The odd output phase is therefore the input delayed by 13 input samples, and it needs no arithmetic. The even phase is a 28-tap polyphase branch with mirror-symmetric coefficients. Mirrored sample pairs are added first, so only 14 multipliers are needed per channel. The 14 distinct coefficients are a parameter array of signed 18-bit values with 17 fraction bits. The I and Q channels share the coefficients and have the same latency.

Top module: `hb_interp2x`

## Requirements
- R1: After reset, out_valid, out_i and out_q are 0, and the sample history is all zeros. The first outputs after reset are computed as if every earlier input were 0.
- R2: An input accepted at a rising edge (in_valid high) produces exactly two output strobes. The filtered sample is registered at the 5th rising edge, counting the capturing edge as the first. The delayed sample is registered at the 6th edge. out_valid is low in every other cycle.
- R3: Let x[m] be the sample just accepted. The filtered sample is the sum over j = 0..27 of c[j]·x[m−j], where c[j] = COEF[j] for j < 14 and c[j] = COEF[27−j] otherwise. Each COEF element is a signed 18-bit value with 17 fraction bits.
- R4: The full-precision sum is rounded by adding 2^16 and then shifting right arithmetically by 17 bits (floor).
- R5: The rounded filtered value saturates to the range −32768..32767.
- R6: The delayed sample equals x[m−13] exactly, with no scaling or rounding.
- R7: The I and Q channels are computed independently, with the same coefficients and the same latency. Equal I and Q inputs give equal I and Q outputs.
- R8: While out_valid is low, out_i and out_q keep their last values.
- R9: in_valid is never high on two consecutive clocks, and gaps of any length between inputs are allowed. Data presented while in_valid is low is ignored and does not enter the history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processing clock at twice the input sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe, at most every second clock |
| in_i | input | 16 | Input in-phase sample, signed |
| in_q | input | 16 | Input quadrature sample, signed |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Output in-phase sample, signed |
| out_q | output | 16 | Output quadrature sample, signed |

## Verification
The bench numbers every rising edge. When an input is captured at edge n, it schedules the filtered result for edge n+4 and the delayed copy for edge n+5. This matches the five and six edges of R2, counting edge n as the first. Outputs are compared on the falling edge after each rising edge. That cycle must carry exactly the scheduled pair, or no strobe with the data held. Idle cycles carry random data to confirm it is ignored. Input spacings of two to five clocks confirm that the latency does not depend on the gap.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

   // register stages inside the filtered branch: pre-add, multiply, accumulate
   localparam int HBI_MAC_STAGES = 3;

   // default distinct even-phase coefficients, outermost first, Q1.17,
   // scaled for interpolation gain 2 (the 28 mirrored taps sum to 2^17)
   localparam logic signed [17:0] HBI_DEF_COEF [14] = '{
      -18'sd80,    18'sd200,   -18'sd400,   18'sd700,
      -18'sd1100,  18'sd1700,  -18'sd2500,  18'sd3600,
      -18'sd5000,  18'sd7000,  -18'sd10000, 18'sd15200,
      -18'sd26500, 18'sd82716
   };

   typedef enum logic {
      PH_FILT   = 1'b0,
      PH_CENTRE = 1'b1
   } hbi_phase_e;

endpackage

// File: rtl/hbi_tap_line.sv
module hbi_tap_line #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 28
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          shift_en,
   input  logic [DATA_W-1:0]             din,
   output logic [DEPTH-1:0][DATA_W-1:0]  taps
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        taps[0] <= '0;
      else if (shift_en) taps[0] <= din;
   end

   for (genvar k = 1; k < DEPTH; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        taps[k] <= '0;
         else if (shift_en) taps[k] <= taps[k-1];
      end
   end

endmodule

// File: rtl/hbi_branch_mac.sv
module hbi_branch_mac #(
   parameter int DATA_W    = 16,
   parameter int COEF_W    = 18,
   parameter int COEF_FRAC = 17,
   parameter int DEPTH     = 28,
   parameter bit FOLD      = 1'b1,
   parameter logic signed [COEF_W-1:0] COEF [DEPTH/2] = hbi_pkg::HBI_DEF_COEF
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [DEPTH-1:0][DATA_W-1:0]  taps,
   output logic [DATA_W-1:0]             filt
);

   localparam int UNIQ   = DEPTH / 2;
   localparam int N_OP   = FOLD ? UNIQ : DEPTH;
   localparam int PRE_W  = DATA_W + 1;
   localparam int PROD_W = PRE_W + COEF_W;
   localparam int ACC_W  = PROD_W + $clog2(N_OP) + 1;

   localparam logic signed [ACC_W-1:0] RND_HALF = ACC_W'(1) << (COEF_FRAC - 1);
   localparam logic signed [ACC_W-1:0] OUT_MAX  = (ACC_W'(1) << (DATA_W - 1)) - ACC_W'(1);
   localparam logic signed [ACC_W-1:0] OUT_MIN  = -(ACC_W'(1) << (DATA_W - 1));

   logic signed [PRE_W-1:0]  pre_q  [N_OP];
   logic signed [PROD_W-1:0] prod_q [N_OP];
   logic signed [ACC_W-1:0]  tot;
   logic signed [ACC_W-1:0]  acc_q;
   logic signed [ACC_W-1:0]  biased;
   logic signed [ACC_W-1:0]  shifted;

   for (genvar j = 0; j < N_OP; j++) begin : g_op
      localparam int CI = (j < UNIQ) ? j : (DEPTH - 1 - j);

      if (FOLD) begin : g_fold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pre_q[j] <= '0;
            else        pre_q[j] <= PRE_W'($signed(taps[j])) +
                                    PRE_W'($signed(taps[DEPTH-1-j]));
         end
      end else begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pre_q[j] <= '0;
            else        pre_q[j] <= PRE_W'($signed(taps[j]));
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prod_q[j] <= '0;
         else        prod_q[j] <= PROD_W'(pre_q[j]) * PROD_W'(COEF[CI]);
      end
   end

   always_comb begin
      tot = '0;
      for (int j = 0; j < N_OP; j++) tot = tot + ACC_W'(prod_q[j]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= tot;
   end

   always_comb begin
      biased  = acc_q + RND_HALF;
      shifted = biased >>> COEF_FRAC;
      if (shifted > OUT_MAX)      filt = OUT_MAX[DATA_W-1:0];
      else if (shifted < OUT_MIN) filt = OUT_MIN[DATA_W-1:0];
      else                        filt = shifted[DATA_W-1:0];
   end

endmodule

// File: rtl/hbi_phase_seq.sv
module hbi_phase_seq #(
   parameter int DATA_W = 16,
   parameter int NCH    = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic [NCH-1:0][DATA_W-1:0]  filt_in,
   input  logic [NCH-1:0][DATA_W-1:0]  centre_in,
   output logic                        out_valid,
   output logic [NCH-1:0][DATA_W-1:0]  out_data
);
   import hbi_pkg::*;

   localparam int VP_LEN = HBI_MAC_STAGES + 1;
   localparam int CP_LEN = HBI_MAC_STAGES + 1;

   logic [VP_LEN-1:0]               vpipe;
   logic                            second_q;
   logic [NCH-1:0][DATA_W-1:0]      cpipe [CP_LEN];
   hbi_phase_e                      sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vpipe <= '0;
      else        vpipe <= {vpipe[VP_LEN-2:0], in_valid};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cpipe[0] <= '0;
      else        cpipe[0] <= centre_in;
   end

   for (genvar k = 1; k < CP_LEN; k++) begin : g_cpipe
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cpipe[k] <= '0;
         else        cpipe[k] <= cpipe[k-1];
      end
   end

   always_comb sel = vpipe[VP_LEN-1] ? PH_FILT : PH_CENTRE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         second_q  <= 1'b0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         second_q <= vpipe[VP_LEN-1];
         if (vpipe[VP_LEN-1] || second_q) begin
            out_valid <= 1'b1;
            out_data  <= (sel == PH_FILT) ? filt_in : cpipe[CP_LEN-1];
         end else begin
            out_valid <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/hb_interp2x.sv
module hb_interp2x #(
   parameter int DATA_W    = 16,
   parameter int COEF_W    = 18,
   parameter int COEF_FRAC = 17,
   parameter int NUM_TAPS  = 55,
   parameter bit FOLD      = 1'b1,
   parameter logic signed [COEF_W-1:0] COEF [(NUM_TAPS+1)/4] = hbi_pkg::HBI_DEF_COEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_i,
   input  logic [DATA_W-1:0] in_q,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_i,
   output logic [DATA_W-1:0] out_q
);

   localparam int NCH    = 2;
   localparam int DEPTH  = (NUM_TAPS + 1) / 2;
   localparam int CENTRE = DEPTH / 2 - 1;

   if (NUM_TAPS % 4 != 3) begin : g_bad_taps
      $error("half-band length must be 4k+3");
   end
   if (COEF_FRAC >= COEF_W) begin : g_bad_frac
      $error("coefficient fraction exceeds coefficient width");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("data width too small");
   end

   logic [NCH-1:0][DATA_W-1:0] ch_in;
   logic [NCH-1:0][DATA_W-1:0] ch_filt;
   logic [NCH-1:0][DATA_W-1:0] ch_centre;
   logic [NCH-1:0][DATA_W-1:0] ch_out;

   assign ch_in[0] = in_i;
   assign ch_in[1] = in_q;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [DEPTH-1:0][DATA_W-1:0] taps;

      hbi_tap_line #(
         .DATA_W (DATA_W),
         .DEPTH  (DEPTH)
      ) u_line (
         .clk      (clk),
         .rst_n    (rst_n),
         .shift_en (in_valid),
         .din      (ch_in[c]),
         .taps     (taps)
      );

      hbi_branch_mac #(
         .DATA_W    (DATA_W),
         .COEF_W    (COEF_W),
         .COEF_FRAC (COEF_FRAC),
         .DEPTH     (DEPTH),
         .FOLD      (FOLD),
         .COEF      (COEF)
      ) u_mac (
         .clk   (clk),
         .rst_n (rst_n),
         .taps  (taps),
         .filt  (ch_filt[c])
      );

      assign ch_centre[c] = taps[CENTRE];
   end

   hbi_phase_seq #(
      .DATA_W (DATA_W),
      .NCH    (NCH)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .filt_in   (ch_filt),
      .centre_in (ch_centre),
      .out_valid (out_valid),
      .out_data  (ch_out)
   );

   assign out_i = ch_out[0];
   assign out_q = ch_out[1];

endmodule

// File: rtl/hbi_checker.sv
module hbi_checker #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_i,
   input logic [DATA_W-1:0] out_q
);

   AST_IN_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> !in_valid); // R9

   AST_FILT_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##5 out_valid); // R2

   AST_CENTRE_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##6 out_valid); // R2

   AST_NO_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($past(in_valid, 5) || $past(in_valid, 6))); // R2

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(out_i) && $stable(out_q))); // R8

endmodule

bind hb_interp2x hbi_checker #(.DATA_W(DATA_W)) u_hbi_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_i     (out_i),
   .out_q     (out_q)
);

// File: tb/test_hb_interp2x.sv
`timescale 1ns/1ps
module test_hb_interp2x;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_i = '0;
   logic [15:0] in_q = '0;
   logic        out_valid;
   logic [15:0] out_i;
   logic [15:0] out_q;

   hb_interp2x i_hb_interp2x (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_i      (in_i),
      .in_q      (in_q),
      .out_valid (out_valid),
      .out_i     (out_i),
      .out_q     (out_q)
   );

   always #2.5 clk = ~clk;

   int total = 0;
   int bad   = 0;
   bit done  = 0;
   bit chk_on = 0;
   bit iq_same = 0;
   int ecnt = 0;

   // distinct coefficients of R3, outermost first
   int cf [14] = '{-80, 200, -400, 700, -1100, 1700, -2500, 3600,
                   -5000, 7000, -10000, 15200, -26500, 82716};
   int hist_i [28];
   int hist_q [28];
   int exp_i [int];
   int exp_q [int];
   string exp_tag [int];
   int last_i = 0;
   int last_q = 0;

   function automatic int filt_model(input int h [28]);
      longint acc = 0;
      longint r;
      for (int j = 0; j < 28; j++) begin
         int c = (j < 14) ? cf[j] : cf[27-j];
         acc += longint'(c) * longint'(h[j]);
      end
      r = (acc + 65536) >>> 17;          // R4
      if (r > 32767)  r = 32767;         // R5
      if (r < -32768) r = -32768;
      return int'(r);
   endfunction

   task automatic check(input string tag, input int act, input int expv, input string what);
      total++;
      if (act != expv) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d (edge %0d)", tag, what, act, expv, ecnt);
      end
   endtask

   // reference model: runs at every rising edge
   always @(posedge clk) begin
      ecnt = ecnt + 1;
      if (rst_n && in_valid) begin
         for (int k = 27; k > 0; k--) begin
            hist_i[k] = hist_i[k-1];
            hist_q[k] = hist_q[k-1];
         end
         hist_i[0] = int'($signed(in_i));
         hist_q[0] = int'($signed(in_q));
         exp_i[ecnt+4] = filt_model(hist_i);    // R3
         exp_q[ecnt+4] = filt_model(hist_q);
         exp_tag[ecnt+4] = "R3";
         exp_i[ecnt+5] = hist_i[13];            // R6
         exp_q[ecnt+5] = hist_q[13];
         exp_tag[ecnt+5] = "R6";
      end
   end

   // comparison on every falling edge
   always @(negedge clk) begin
      if (chk_on && !done) begin
         if (exp_i.exists(ecnt)) begin
            check("R2", int'(out_valid), 1, "out_valid on due cycle");
            check(exp_tag[ecnt], int'($signed(out_i)), exp_i[ecnt], "out_i");
            check(exp_tag[ecnt], int'($signed(out_q)), exp_q[ecnt], "out_q");
            if (iq_same) check("R7", int'($signed(out_q)), int'($signed(out_i)), "I/Q equal");
            last_i = int'($signed(out_i));
            last_q = int'($signed(out_q));
            exp_i.delete(ecnt);
            exp_q.delete(ecnt);
            exp_tag.delete(ecnt);
         end else begin
            check("R2", int'(out_valid), 0, "out_valid idle");
            check("R8", int'($signed(out_i)), last_i, "out_i hold");
            check("R8", int'($signed(out_q)), last_q, "out_q hold");
         end
      end
   end

   // one sample followed by gap idle clocks of random data (R9)
   task automatic send(input int vi, input int vq, input int gap);
      @(negedge clk);
      in_valid = 1'b1;
      in_i = 16'(vi);
      in_q = 16'(vq);
      @(negedge clk);
      in_valid = 1'b0;
      in_i = 16'($urandom);
      in_q = 16'($urandom);
      for (int g = 0; g < gap; g++) begin
         @(negedge clk);
         in_i = 16'($urandom);
         in_q = 16'($urandom);
      end
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      for (int k = 0; k < 28; k++) begin hist_i[k] = 0; hist_q[k] = 0; end
      repeat (6) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1", int'(out_valid), 0, "out_valid after reset");
      check("R1", int'(out_i), 0, "out_i after reset");
      check("R1", int'(out_q), 0, "out_q after reset");
      chk_on = 1;

      // R1/R3/R7: impulse on zero history, opposite signs on I and Q
      send(16384, -16384, 0);
      for (int k = 0; k < 30; k++) send(0, 0, 0);

      // R3/R5: full-scale DC, gap 1
      for (int k = 0; k < 32; k++) send(32767, -32768, 1);
      for (int k = 0; k < 30; k++) send(0, 0, 0);

      // R5: alternating full scale drives both saturation limits
      for (int k = 0; k < 40; k++) send((k % 2) ? -32768 : 32767, (k % 2) ? 32767 : -32768, 0);
      for (int k = 0; k < 30; k++) send(0, 0, 0);

      // R4: small values exercise the rounding boundary
      for (int k = 0; k < 40; k++) send((k % 3) - 1, 1 - (k % 5), 0);

      // R9: random data with random gaps of idle random data
      for (int k = 0; k < 400; k++)
         send(int'($signed(16'($urandom))), int'($signed(16'($urandom))), int'($urandom_range(0, 3)));

      // R7: identical I and Q must give identical outputs
      for (int k = 0; k < 30; k++) send(0, 0, 0);
      idle(10);
      iq_same = 1;
      for (int k = 0; k < 60; k++) begin
         int v = int'($signed(16'($urandom)));
         send(v, v, int'($urandom_range(0, 2)));
      end
      idle(12);
      iq_same = 0;

      idle(20);
      if (!done) begin
         // every scheduled output must have been observed
         check("R2", exp_i.num(), 0, "pending outputs");
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule